// File: doc/BRIEF.md
# CCD still-capture shutter sequencer

This block times the two shutter-related outputs of a CCD timing generator while a still picture is taken with a mechanical shutter. One output is the charge-drain line (SUB). The other is the substrate-bias switch (SUBSW). The block watches the horizontal sync pulse, the vertical sync pulse, a horizontal-blank level and an external trigger. It reads a few mode fields that a serial control interface elsewhere has already loaded.

Once still mode is enabled, the block drains the sensor on every line by pulsing SUB low during horizontal blank. A falling trigger edge marks the shutter opening. From the end of the next blank, SUB is held high and charge integrates. A start event is then either a trigger rising edge or a vertical sync pulse, depending on a select bit. The start event arms readout, and the block counts horizontal sync pulses until SUBSW rises at a programmed position. SUBSW then stays high through the readout field. It stays high after still mode is cleared, until the first horizontal sync that follows the next vertical sync. A separate guard flags vertical sync intervals that are too short.

Top module: `ccd_still_seq`

## Requirements
- R1: After reset, `sub_out`, `subsw_out`, `armed` and `vd_err` are all 0.
- R2: With `still_en`=1 and `sub_sel_serial`=0, before any trigger, `sub_out` is 0 while `hblank_in` is 1 and is 1 while `hblank_in` is 0. The output follows the blank input one clock later.
- R3: With `sub_sel_serial`=1, during the drain and integration phases `sub_out` copies `sub_es_in` one clock later and ignores `hblank_in`.
- R4: A falling edge on `trg_in` during draining is remembered. The blank that follows it still drains. When that blank ends, `sub_out` goes to 1 and stays 1, including during later blanks.
- R5: The start event is a rising edge of `trg_in` when `trig_sel_trg`=1, and a rising edge of `vd_in` when `trig_sel_trg`=0. The other source has no effect. The start event sets `armed` to 1. `armed` and `subsw_out` are never 1 together.
- R6: With a programmed position N in `subsw_pos`, the first N horizontal sync pulses after the start event leave `subsw_out` at 0. On the next pulse (number N+1), `subsw_out` rises and `armed` drops.
- R7: Once `subsw_out` is high, clearing `still_en` does not lower it. It stays high through any number of lines and through the next rising edge of `vd_in`. It falls on the first rising edge of `hd_in` after that edge.
- R8: Clearing `still_en` before `subsw_out` has risen returns the block to idle: `sub_out`, `subsw_out` and `armed` are 0, and `subsw_out` does not rise on later lines.
- R9: The position is copied from `subsw_pos` on each horizontal sync pulse while no capture is running. A value written while `subsw_out` is high leaves that output unchanged and applies to the next capture. A position of 0 makes `subsw_out` rise on the first horizontal sync after the start event.
- R10: On each rising edge of `vd_in` except the first after reset, `vd_err` is updated and then held until the next such edge. It becomes 1 if fewer than 91 horizontal sync pulses came since the previous edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_in | input | 1 | Horizontal sync pulse, asynchronous |
| vd_in | input | 1 | Vertical sync pulse, asynchronous |
| trg_in | input | 1 | External shutter trigger, asynchronous |
| hblank_in | input | 1 | Horizontal blank level, block clock domain |
| still_en | input | 1 | Still mode enable field |
| trig_sel_trg | input | 1 | Start source: 1 = trigger rising edge, 0 = vertical sync |
| sub_sel_serial | input | 1 | SUB source: 1 = serial integration-time pulse, 0 = trigger-driven |
| sub_es_in | input | 1 | SUB level from the serial integration-time logic |
| subsw_pos | input | POS_W | SUBSW rise position in horizontal sync pulses |
| sub_out | output | 1 | Charge-drain output |
| subsw_out | output | 1 | Substrate-bias switch output |
| armed | output | 1 | Readout armed, counting toward the SUBSW rise |
| vd_err | output | 1 | Last vertical sync interval was too short |

## Verification
The sequencer state shows up at the ports through SUB, SUBSW and the armed flag, so the bench probes each state at specific points in the line.

- A sequencer stuck in the wrong state misreads SUB within one line. SUB keeps pulsing in blank when it should be held, or it goes quiet too early.
- A line counter or position shadow that is off by one moves the SUBSW rise by a whole line. This shows at the end of the line where the rise is expected.
- A bad exit path either drops SUBSW before the vertical sync or holds it past the next horizontal sync.
- A wrong interval count changes `vd_err` at the 90- and 91-line boundaries.

// File: rtl/still_seq_pkg.sv
`timescale 1ns/1ps
package still_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_DRAIN    = 3'd1,
      ST_INTEG    = 3'd2,
      ST_WAIT_CNT = 3'd3,
      ST_SW_HIGH  = 3'd4,
      ST_EXIT_VD  = 3'd5,
      ST_EXIT_HD  = 3'd6
   } seq_state_t;

   // event strobe indices
   localparam int unsigned EV_HD_RISE  = 0;
   localparam int unsigned EV_VD_RISE  = 1;
   localparam int unsigned EV_TRG_RISE = 2;
   localparam int unsigned EV_TRG_FALL = 3;
   localparam int unsigned EV_NUM      = 4;
endpackage

// File: rtl/still_edge_sync.sv
`timescale 1ns/1ps
module still_edge_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic strobe
);
   initial begin
      assert (STAGES >= 2) else $error("still_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         last_q <= sync_q[STAGES-1];
      end
   end

   generate
      if (FALLING) begin : g_fall
         assign strobe = ~sync_q[STAGES-1] & last_q;
      end else begin : g_rise
         assign strobe = sync_q[STAGES-1] & ~last_q;
      end
   endgenerate
endmodule

// File: rtl/still_vd_guard.sv
`timescale 1ns/1ps
module still_vd_guard #(
   parameter int unsigned MIN_LINES = 91
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hd_rise,
   input  logic vd_rise,
   output logic err_o
);
   localparam int unsigned CW = $clog2(MIN_LINES + 1);

   initial begin
      assert (MIN_LINES >= 2) else $error("still_vd_guard: MIN_LINES too small");
   end

   logic [CW-1:0] line_cnt;
   logic          seen_q;
   logic          err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         seen_q   <= 1'b0;
         err_q    <= 1'b0;
      end else if (vd_rise) begin
         err_q    <= seen_q && (line_cnt < CW'(MIN_LINES));
         seen_q   <= 1'b1;
         line_cnt <= '0;
      end else if (hd_rise && (line_cnt < CW'(MIN_LINES))) begin
         line_cnt <= line_cnt + 1'b1;
      end
   end

   assign err_o = err_q;

   // R10
   err_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_q) |-> $past(vd_rise));
endmodule

// File: rtl/still_seq_fsm.sv
`timescale 1ns/1ps
module still_seq_fsm
   import still_seq_pkg::*;
#(
   parameter int unsigned POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hd_rise,
   input  logic             vd_rise,
   input  logic             trg_rise,
   input  logic             trg_fall,
   input  logic             hblank,
   input  logic             still_en,
   input  logic             trig_sel_trg,
   input  logic             sub_sel_serial,
   input  logic             sub_es,
   input  logic [POS_W-1:0] pos_cfg,
   output logic             sub_o,
   output logic             subsw_o,
   output logic             armed_o
);
   seq_state_t       st, st_nx;
   logic [POS_W-1:0] pos_shadow;
   logic [POS_W-1:0] line_cnt;
   logic             flag_q;
   logic             hb_q;
   logic             sub_q, sub_nx;
   logic             subsw_q, subsw_nx;
   logic             start_ev;
   logic             hb_fall;
   logic             shadow_open;

   assign start_ev    = trig_sel_trg ? trg_rise : vd_rise;
   assign hb_fall     = hb_q & ~hblank;
   assign shadow_open = (st == ST_IDLE) || (st == ST_DRAIN) || (st == ST_INTEG);

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:     if (still_en) st_nx = ST_DRAIN;
         ST_DRAIN: begin
            if (!still_en)                st_nx = ST_IDLE;
            else if (start_ev)            st_nx = ST_WAIT_CNT;
            else if (flag_q && hb_fall)   st_nx = ST_INTEG;
         end
         ST_INTEG: begin
            if (!still_en)      st_nx = ST_IDLE;
            else if (start_ev)  st_nx = ST_WAIT_CNT;
         end
         ST_WAIT_CNT: begin
            if (!still_en)                              st_nx = ST_IDLE;
            else if (hd_rise && (line_cnt == pos_shadow)) st_nx = ST_SW_HIGH;
         end
         ST_SW_HIGH:  if (!still_en) st_nx = ST_EXIT_VD;
         ST_EXIT_VD:  if (vd_rise)   st_nx = ST_EXIT_HD;
         ST_EXIT_HD:  if (hd_rise)   st_nx = ST_IDLE;
         default:                    st_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      case (st_nx)
         ST_IDLE:  sub_nx = 1'b0;
         ST_DRAIN: sub_nx = sub_sel_serial ? sub_es : ~hblank;
         ST_INTEG: sub_nx = sub_sel_serial ? sub_es : 1'b1;
         default:  sub_nx = 1'b1;
      endcase
      subsw_nx = (st_nx == ST_SW_HIGH) || (st_nx == ST_EXIT_VD) || (st_nx == ST_EXIT_HD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         pos_shadow <= '0;
         line_cnt   <= '0;
         flag_q     <= 1'b0;
         hb_q       <= 1'b0;
         sub_q      <= 1'b0;
         subsw_q    <= 1'b0;
      end else begin
         st      <= st_nx;
         hb_q    <= hblank;
         sub_q   <= sub_nx;
         subsw_q <= subsw_nx;
         flag_q  <= ((st == ST_DRAIN) && (st_nx == ST_DRAIN)) ? (flag_q | trg_fall) : 1'b0;
         if (hd_rise && shadow_open) pos_shadow <= pos_cfg;
         if (st != ST_WAIT_CNT)      line_cnt <= '0;
         else if (hd_rise)           line_cnt <= line_cnt + 1'b1;
      end
   end

   assign sub_o   = sub_q;
   assign subsw_o = subsw_q;
   assign armed_o = (st == ST_WAIT_CNT);

   // R6
   subsw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(subsw_q) |-> ($past(st) == ST_WAIT_CNT) && $past(hd_rise));

   // R7
   subsw_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(subsw_q) |-> ($past(st) == ST_EXIT_HD) && $past(hd_rise));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (!sub_q && !subsw_q));

   // R5
   armed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o |-> !subsw_q);
endmodule

// File: rtl/ccd_still_seq.sv
`timescale 1ns/1ps
module ccd_still_seq
   import still_seq_pkg::*;
#(
   parameter int unsigned POS_W       = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LINES   = 91
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hd_in,
   input  logic             vd_in,
   input  logic             trg_in,
   input  logic             hblank_in,
   input  logic             still_en,
   input  logic             trig_sel_trg,
   input  logic             sub_sel_serial,
   input  logic             sub_es_in,
   input  logic [POS_W-1:0] subsw_pos,
   output logic             sub_out,
   output logic             subsw_out,
   output logic             armed,
   output logic             vd_err
);
   localparam logic [EV_NUM-1:0] EV_FALL_MASK = EV_NUM'(1) << EV_TRG_FALL;

   initial begin
      assert (POS_W >= 1 && POS_W <= 16) else $error("ccd_still_seq: POS_W out of range");
   end

   logic [EV_NUM-1:0] ev_src;
   logic [EV_NUM-1:0] ev_str;

   always_comb begin
      ev_src              = '0;
      ev_src[EV_HD_RISE]  = hd_in;
      ev_src[EV_VD_RISE]  = vd_in;
      ev_src[EV_TRG_RISE] = trg_in;
      ev_src[EV_TRG_FALL] = trg_in;
   end

   generate
      for (genvar e = 0; e < EV_NUM; e++) begin : g_ev
         still_edge_sync #(
            .STAGES  (SYNC_STAGES),
            .FALLING (EV_FALL_MASK[e])
         ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (ev_src[e]),
            .strobe (ev_str[e])
         );
      end
   endgenerate

   still_seq_fsm #(.POS_W(POS_W)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .hd_rise        (ev_str[EV_HD_RISE]),
      .vd_rise        (ev_str[EV_VD_RISE]),
      .trg_rise       (ev_str[EV_TRG_RISE]),
      .trg_fall       (ev_str[EV_TRG_FALL]),
      .hblank         (hblank_in),
      .still_en       (still_en),
      .trig_sel_trg   (trig_sel_trg),
      .sub_sel_serial (sub_sel_serial),
      .sub_es         (sub_es_in),
      .pos_cfg        (subsw_pos),
      .sub_o          (sub_out),
      .subsw_o        (subsw_out),
      .armed_o        (armed)
   );

   still_vd_guard #(.MIN_LINES(MIN_LINES)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .hd_rise (ev_str[EV_HD_RISE]),
      .vd_rise (ev_str[EV_VD_RISE]),
      .err_o   (vd_err)
   );
endmodule

// File: tb/sim_ccd_still_seq.sv
`timescale 1ns/1ps
module sim_ccd_still_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hd_in = 1'b0, vd_in = 1'b0, trg_in = 1'b0, hblank_in = 1'b0;
   logic       still_en = 1'b0, trig_sel_trg = 1'b0, sub_sel_serial = 1'b0, sub_es_in = 1'b0;
   logic [5:0] subsw_pos = 6'd0;
   logic       sub_out, subsw_out, armed, vd_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      string tag;
      int    sel;
      logic  val;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   ccd_still_seq u0 (
      .clk(clk), .rst_n(rst_n), .hd_in(hd_in), .vd_in(vd_in), .trg_in(trg_in),
      .hblank_in(hblank_in), .still_en(still_en), .trig_sel_trg(trig_sel_trg),
      .sub_sel_serial(sub_sel_serial), .sub_es_in(sub_es_in), .subsw_pos(subsw_pos),
      .sub_out(sub_out), .subsw_out(subsw_out), .armed(armed), .vd_err(vd_err)
   );

   // monitor: pops expectations and compares with the sampled outputs
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t it;
         logic act;
         it = sb_q.pop_front();
         case (it.sel)
            0:       act = sub_out;
            1:       act = subsw_out;
            2:       act = armed;
            default: act = vd_err;
         endcase
         total++;
         if (act !== it.val) begin
            bad++;
            $display("FAIL %s sel=%0d actual=%b expected=%b", it.tag, it.sel, act, it.val);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input string tag, input int sel, input logic v);
      exp_t it;
      it.tag = tag; it.sel = sel; it.val = v;
      sb_q.push_back(it);
   endtask

   task automatic line();
      hd_in = 1'b1; hblank_in = 1'b1;
      tick(2); hd_in = 1'b0;
      tick(4); hblank_in = 1'b0;
      tick(14);
   endtask

   task automatic line_blank_chk(input string tag, input logic exp_sub);
      hd_in = 1'b1; hblank_in = 1'b1;
      tick(2); hd_in = 1'b0;
      tick(2); expect_out(tag, 0, exp_sub);
      tick(2); hblank_in = 1'b0;
      tick(14);
   endtask

   task automatic vd_pulse();
      vd_in = 1'b1; tick(3); vd_in = 1'b0; tick(6);
   endtask

   task automatic trg_set(input logic v);
      trg_in = v; tick(6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      trg_in = 1'b1; trig_sel_trg = 1'b1; subsw_pos = 6'd3;
      tick(4); rst_n = 1'b1; tick(4);
      // R1 reset state
      expect_out("R1 sub", 0, 1'b0); expect_out("R1 subsw", 1, 1'b0);
      expect_out("R1 armed", 2, 1'b0); expect_out("R1 vd_err", 3, 1'b0);
      tick(1);
      // R2 drain pulses
      still_en = 1'b1; tick(3);
      expect_out("R2 sub outside blank", 0, 1'b1);
      line_blank_chk("R2 sub in blank", 1'b0);
      expect_out("R2 sub after blank", 0, 1'b1);
      expect_out("R2 not armed", 2, 1'b0);
      // R3 serial sub source
      sub_sel_serial = 1'b1; sub_es_in = 1'b0; tick(3);
      expect_out("R3 sub follows es low", 0, 1'b0);
      sub_es_in = 1'b1; tick(3);
      expect_out("R3 sub follows es high", 0, 1'b1);
      line_blank_chk("R3 blank ignored", 1'b1);
      sub_sel_serial = 1'b0; sub_es_in = 1'b0; tick(3);
      // R4 trigger fall, integration
      trg_set(1'b0);
      line_blank_chk("R4 blank after fall still drains", 1'b0);
      expect_out("R4 sub high after blank", 0, 1'b1);
      line_blank_chk("R4 integrating blank", 1'b1);
      expect_out("R4 not armed", 2, 1'b0);
      // R5 start by trigger rise, R6 count of 3
      trg_set(1'b1);
      expect_out("R5 armed on trg rise", 2, 1'b1);
      expect_out("R5 subsw low while armed", 1, 1'b0);
      line(); line(); line();
      expect_out("R6 subsw low after 3 HD", 1, 1'b0);
      expect_out("R6 still armed", 2, 1'b1);
      line();
      expect_out("R6 subsw high on 4th HD", 1, 1'b1);
      expect_out("R6 armed drops", 2, 1'b0);
      // R9 write while high has no effect now
      subsw_pos = 6'd0; line();
      expect_out("R9 subsw unchanged by write", 1, 1'b1);
      // R7 exit sequence
      still_en = 1'b0; tick(3);
      expect_out("R7 subsw held after clear", 1, 1'b1);
      line(); line();
      expect_out("R7 subsw held over lines", 1, 1'b1);
      vd_pulse();
      expect_out("R7 subsw held after VD", 1, 1'b1);
      expect_out("R10 first VD no error", 3, 1'b0);
      line();
      expect_out("R7 subsw low after HD", 1, 1'b0);
      expect_out("R7 sub low in idle", 0, 1'b0);
      // R5 VD source, R9 position zero
      trig_sel_trg = 1'b0; still_en = 1'b1; tick(3);
      line(); line();
      trg_set(1'b0); line();
      trg_set(1'b1);
      expect_out("R5 trg ignored with VD source", 2, 1'b0);
      vd_pulse();
      expect_out("R5 armed on VD", 2, 1'b1);
      expect_out("R10 short interval error", 3, 1'b1);
      line();
      expect_out("R9 zero position rises on first HD", 1, 1'b1);
      expect_out("R9 armed drops", 2, 1'b0);
      still_en = 1'b0; tick(3); vd_pulse(); line();
      expect_out("R7 second exit subsw low", 1, 1'b0);
      // R8 abort while armed
      subsw_pos = 6'd5; trig_sel_trg = 1'b1; still_en = 1'b1; tick(3);
      line(); line();
      trg_set(1'b0); trg_set(1'b1);
      expect_out("R8 armed before abort", 2, 1'b1);
      line();
      still_en = 1'b0; tick(3);
      expect_out("R8 armed cleared", 2, 1'b0);
      expect_out("R8 sub cleared", 0, 1'b0);
      expect_out("R8 subsw low", 1, 1'b0);
      line(); line();
      expect_out("R8 subsw stays low", 1, 1'b0);
      // R10 interval boundaries
      vd_pulse();
      for (int i = 0; i < 90; i++) line();
      vd_pulse();
      expect_out("R10 90 lines flagged", 3, 1'b1);
      for (int i = 0; i < 91; i++) line();
      vd_pulse();
      expect_out("R10 91 lines accepted", 3, 1'b0);
      tick(3);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule